// File: doc/BRIEF.md
# Extended RAM and Nametable Mapper

This block holds a small on-cartridge scratch RAM (1 KB by default) that the CPU can reach through a fixed address window. It also steers each of the four 1 KB nametable quadrants seen by the video fetch unit to one of four sources. A 2-bit RAM mode register decides how the CPU may use the RAM. In the low modes the RAM serves the video side, and a CPU write made while the picture is not being drawn stores zero. In the high modes the RAM is a CPU work area. In one of those modes it is read-only.

On the video side, the quadrant is taken from two video address bits. A per-quadrant selector then does one of three things:
- It sends the access to one of the two console RAM pages, giving out the page address and a write strobe.
- It returns the scratch RAM byte.
- It returns a fill byte. The fill byte is either the tile value or the colour value, chosen by the fetch phase of the horizontal counter.

Video writes only ever reach the console RAM. The console RAM itself lives outside this block.

Top module: `xram_ntmap`

## Requirements
- R1: After reset the RAM mode is 0 and all four quadrant selectors are 0. A CPU read in the window returns `cpu_bus_last`, and every quadrant routes to console page 0.
- R2: A CPU access hits the RAM only when `cpu_addr[15:10]` equals `6'b010111` (the window 0x5C00 to 0x5FFF). The RAM index is `cpu_addr[9:0]`. Writes outside the window leave the RAM unchanged, and reads there return `cpu_bus_last`.
- R3: A window read returns the RAM byte when the mode is 2 or 3. It returns `cpu_bus_last` when the mode is 0 or 1.
- R4: In modes 0 and 1, a window write stores `cpu_wdata` while `rendering` is 1 and stores 0x00 while it is 0.
- R5: In mode 2 a window write always stores `cpu_wdata`. In mode 3 window writes are ignored.
- R6: A CPU write to 0x5104 loads the mode from `cpu_wdata[1:0]`. A CPU write to 0x5105 loads the selector of quadrant q from `cpu_wdata[2q+1:2q]`. Selector codes are: 0 console page 0, 1 console page 1, 2 scratch RAM, 3 fill.
- R7: The quadrant is `vid_addr[11:10]`. For selector 0 or 1, `ciram_hit` is 1, `ciram_addr` is `{selector[0], vid_addr[9:0]}`, and `vid_rdata` is 0x00. For selector 2 or 3, `ciram_hit` is 0.
- R8: For selector 2, `vid_rdata` is the RAM byte at `vid_addr[9:0]` when the mode is 0 or 1, and 0x00 when it is 2 or 3.
- R9: For selector 3, `vid_rdata` is `fill_tile` when `hcount[1]` is 0 and `fill_color` when it is 1.
- R10: `ciram_we` equals `vid_wr` for selectors 0 and 1 and is 0 for selectors 2 and 3. A video write never changes the scratch RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_bus_last | input | 8 | Last value seen on the CPU data bus |
| cpu_rdata | output | 8 | CPU read data |
| rendering | input | 1 | High while a frame is being drawn |
| vid_addr | input | 14 | Video fetch address |
| vid_wr | input | 1 | Video write strobe |
| vid_wdata | input | 8 | Video write data |
| hcount | input | 9 | Horizontal fetch counter |
| fill_tile | input | 8 | Fill tile byte |
| fill_color | input | 8 | Fill colour byte |
| vid_rdata | output | 8 | Data returned to the video fetch |
| ciram_hit | output | 1 | Access routed to console RAM |
| ciram_addr | output | 11 | Console RAM address (page bit and offset) |
| ciram_we | output | 1 | Console RAM write strobe |
| ciram_wdata | output | 8 | Console RAM write data |

## Verification
The bench builds the block with its default parameters, including the unregistered output variant (`OUT_REG = 0`). With that build every read port answers in the cycle it is addressed, and all 1024 RAM locations can be swept one per cycle. The sweep covers every window location in mode 2 and a set of addresses just outside the window. It covers all four modes, with writes made both during and outside rendering. On the video side it covers two selector permutations that put each source on several quadrants, with fill phases taken from a sweep of the horizontal counter.

// File: rtl/xram_pkg.sv
package xram_pkg;

   typedef enum logic [1:0] {
      SRC_PAGE0 = 2'd0,
      SRC_PAGE1 = 2'd1,
      SRC_XRAM  = 2'd2,
      SRC_FILL  = 2'd3
   } nt_src_e;

   typedef logic [1:0] xmode_t;

   localparam int unsigned NUM_QUAD = 4;

endpackage

// File: rtl/xram_regs.sv
module xram_regs
   import xram_pkg::*;
#(
   parameter int unsigned CPU_AW = 16,
   parameter int unsigned DW     = 8,
   parameter logic [CPU_AW-1:0] MODE_ADDR  = 16'h5104,
   parameter logic [CPU_AW-1:0] NTSEL_ADDR = 16'h5105
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cpu_wr,
   input  logic [CPU_AW-1:0]             cpu_addr,
   input  logic [DW-1:0]                 cpu_wdata,
   output xmode_t                        mode_q,
   output logic [NUM_QUAD-1:0][1:0]      sel_q
);

   logic mode_hit;
   logic nt_hit;

   assign mode_hit = cpu_wr && (cpu_addr == MODE_ADDR);
   assign nt_hit   = cpu_wr && (cpu_addr == NTSEL_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n)        mode_q <= '0;
      else if (mode_hit) mode_q <= cpu_wdata[1:0];
   end

   for (genvar q = 0; q < NUM_QUAD; q++) begin : g_quad
      always_ff @(posedge clk) begin
         if (!rst_n)      sel_q[q] <= SRC_PAGE0;
         else if (nt_hit) sel_q[q] <= cpu_wdata[2*q+1 -: 2];
      end
   end

   if (DW > 2*NUM_QUAD) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^cpu_wdata[DW-1:2*NUM_QUAD];
   end

endmodule

// File: rtl/xram_store.sv
module xram_store #(
   parameter int unsigned RAM_AW = 10,
   parameter int unsigned DW     = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [RAM_AW-1:0] wr_idx,
   input  logic [DW-1:0]     wr_data,
   input  logic [RAM_AW-1:0] rd_idx_cpu,
   output logic [DW-1:0]     rd_data_cpu,
   input  logic [RAM_AW-1:0] rd_idx_vid,
   output logic [DW-1:0]     rd_data_vid
);

   localparam int unsigned DEPTH = 1 << RAM_AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   assign rd_data_cpu = mem[rd_idx_cpu];
   assign rd_data_vid = mem[rd_idx_vid];

endmodule

// File: rtl/xram_cpu_side.sv
module xram_cpu_side
   import xram_pkg::*;
#(
   parameter int unsigned CPU_AW = 16,
   parameter int unsigned RAM_AW = 10,
   parameter int unsigned DW     = 8,
   parameter logic [CPU_AW-1:0] WIN_BASE = 16'h5C00
) (
   input  logic              cpu_wr,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DW-1:0]     cpu_wdata,
   input  logic [DW-1:0]     cpu_bus_last,
   input  logic              rendering,
   input  xmode_t            mode,
   input  logic [DW-1:0]     ram_q,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_idx,
   output logic [DW-1:0]     ram_wdata,
   output logic [DW-1:0]     cpu_rdata
);

   localparam int unsigned TAG_W = CPU_AW - RAM_AW;
   localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[CPU_AW-1:RAM_AW];

   logic win_hit;
   logic low_mode;

   assign win_hit  = (cpu_addr[CPU_AW-1:RAM_AW] == WIN_TAG);
   assign low_mode = !mode[1];
   assign ram_idx  = cpu_addr[RAM_AW-1:0];

   always_comb begin
      ram_we    = cpu_wr && win_hit && (mode != 2'd3);
      ram_wdata = (low_mode && !rendering) ? '0 : cpu_wdata;
      cpu_rdata = (win_hit && !low_mode) ? ram_q : cpu_bus_last;
   end

endmodule

// File: rtl/xram_nt_route.sv
module xram_nt_route
   import xram_pkg::*;
#(
   parameter int unsigned VID_AW = 14,
   parameter int unsigned RAM_AW = 10,
   parameter int unsigned DW     = 8,
   parameter int unsigned HC_W   = 9
) (
   input  logic [VID_AW-1:0]        vid_addr,
   input  logic                     vid_wr,
   input  logic [HC_W-1:0]          hcount,
   input  logic [DW-1:0]            fill_tile,
   input  logic [DW-1:0]            fill_color,
   input  xmode_t                   mode,
   input  logic [NUM_QUAD-1:0][1:0] sel_q,
   input  logic [DW-1:0]            ram_q,
   output logic [RAM_AW-1:0]        ram_idx,
   output logic [DW-1:0]            vid_rdata,
   output logic                     ciram_hit,
   output logic [RAM_AW:0]          ciram_addr,
   output logic                     ciram_we
);

   logic [1:0] quad;
   nt_src_e    src;

   assign quad    = vid_addr[RAM_AW+1:RAM_AW];
   assign src     = nt_src_e'(sel_q[quad]);
   assign ram_idx = vid_addr[RAM_AW-1:0];

   always_comb begin
      ciram_hit  = 1'b0;
      ciram_we   = 1'b0;
      ciram_addr = {1'b0, vid_addr[RAM_AW-1:0]};
      vid_rdata  = '0;
      unique case (src)
         SRC_PAGE0, SRC_PAGE1: begin
            ciram_hit  = 1'b1;
            ciram_we   = vid_wr;
            ciram_addr = {src[0], vid_addr[RAM_AW-1:0]};
         end
         SRC_XRAM: vid_rdata = mode[1] ? '0 : ram_q;
         SRC_FILL: vid_rdata = hcount[1] ? fill_color : fill_tile;
         default:  vid_rdata = '0;
      endcase
   end

   logic unused_route;
   if (VID_AW > RAM_AW + 2) begin : g_hi
      assign unused_route = ^{vid_addr[VID_AW-1:RAM_AW+2], hcount[0],
                              hcount[HC_W-1:2]};
   end else begin : g_nohi
      assign unused_route = ^{hcount[0], hcount[HC_W-1:2]};
   end

endmodule

// File: rtl/xram_ntmap.sv
module xram_ntmap
   import xram_pkg::*;
#(
   parameter int unsigned CPU_AW  = 16,
   parameter int unsigned RAM_AW  = 10,
   parameter int unsigned DW      = 8,
   parameter int unsigned VID_AW  = 14,
   parameter int unsigned HC_W    = 9,
   parameter logic [CPU_AW-1:0] WIN_BASE   = 16'h5C00,
   parameter logic [CPU_AW-1:0] MODE_ADDR  = 16'h5104,
   parameter logic [CPU_AW-1:0] NTSEL_ADDR = 16'h5105,
   parameter bit   OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DW-1:0]     cpu_wdata,
   input  logic [DW-1:0]     cpu_bus_last,
   output logic [DW-1:0]     cpu_rdata,
   input  logic              rendering,
   input  logic [VID_AW-1:0] vid_addr,
   input  logic              vid_wr,
   input  logic [DW-1:0]     vid_wdata,
   input  logic [HC_W-1:0]   hcount,
   input  logic [DW-1:0]     fill_tile,
   input  logic [DW-1:0]     fill_color,
   output logic [DW-1:0]     vid_rdata,
   output logic              ciram_hit,
   output logic [RAM_AW:0]   ciram_addr,
   output logic              ciram_we,
   output logic [DW-1:0]     ciram_wdata
);

   if (RAM_AW + 2 > VID_AW) begin : g_bad_vid
      $error("VID_AW too narrow for quadrant select");
   end
   if (RAM_AW >= CPU_AW) begin : g_bad_cpu
      $error("RAM_AW must be below CPU_AW");
   end
   if (DW < 2*NUM_QUAD) begin : g_bad_dw
      $error("DW must hold all quadrant selectors");
   end
   if (HC_W < 2) begin : g_bad_hc
      $error("HC_W must reach the fetch phase bit");
   end
   if ((WIN_BASE & CPU_AW'((1 << RAM_AW) - 1)) != '0) begin : g_bad_base
      $error("WIN_BASE must be aligned to the RAM size");
   end

   xmode_t                   mode_q;
   logic [NUM_QUAD-1:0][1:0] sel_q;
   logic                     ram_we;
   logic [RAM_AW-1:0]        ram_widx;
   logic [DW-1:0]            ram_wdata;
   logic [DW-1:0]            ram_cpu_q;
   logic [RAM_AW-1:0]        ram_vidx;
   logic [DW-1:0]            ram_vid_q;
   logic [DW-1:0]            cpu_rdata_c;
   logic [DW-1:0]            vid_rdata_c;

   xram_regs #(
      .CPU_AW(CPU_AW), .DW(DW), .MODE_ADDR(MODE_ADDR), .NTSEL_ADDR(NTSEL_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .mode_q(mode_q), .sel_q(sel_q)
   );

   xram_cpu_side #(
      .CPU_AW(CPU_AW), .RAM_AW(RAM_AW), .DW(DW), .WIN_BASE(WIN_BASE)
   ) u_cpu (
      .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_bus_last(cpu_bus_last), .rendering(rendering), .mode(mode_q),
      .ram_q(ram_cpu_q), .ram_we(ram_we), .ram_idx(ram_widx),
      .ram_wdata(ram_wdata), .cpu_rdata(cpu_rdata_c)
   );

   xram_store #(.RAM_AW(RAM_AW), .DW(DW)) u_store (
      .clk(clk), .wr_en(ram_we), .wr_idx(ram_widx), .wr_data(ram_wdata),
      .rd_idx_cpu(ram_widx), .rd_data_cpu(ram_cpu_q),
      .rd_idx_vid(ram_vidx), .rd_data_vid(ram_vid_q)
   );

   xram_nt_route #(
      .VID_AW(VID_AW), .RAM_AW(RAM_AW), .DW(DW), .HC_W(HC_W)
   ) u_route (
      .vid_addr(vid_addr), .vid_wr(vid_wr), .hcount(hcount),
      .fill_tile(fill_tile), .fill_color(fill_color), .mode(mode_q),
      .sel_q(sel_q), .ram_q(ram_vid_q), .ram_idx(ram_vidx),
      .vid_rdata(vid_rdata_c), .ciram_hit(ciram_hit),
      .ciram_addr(ciram_addr), .ciram_we(ciram_we)
   );

   assign ciram_wdata = vid_wdata;

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cpu_rdata <= '0;
            vid_rdata <= '0;
         end else begin
            cpu_rdata <= cpu_rdata_c;
            vid_rdata <= vid_rdata_c;
         end
      end
   end else begin : g_ocomb
      assign cpu_rdata = cpu_rdata_c;
      assign vid_rdata = vid_rdata_c;
   end

endmodule

// File: rtl/xram_ntmap_chk.sv
module xram_ntmap_chk
   import xram_pkg::*;
#(
   parameter int unsigned CPU_AW = 16,
   parameter int unsigned RAM_AW = 10,
   parameter int unsigned DW     = 8,
   parameter int unsigned VID_AW = 14,
   parameter logic [CPU_AW-1:0] WIN_BASE  = 16'h5C00,
   parameter logic [CPU_AW-1:0] MODE_ADDR = 16'h5104,
   parameter bit   OUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr,
   input logic [CPU_AW-1:0] cpu_addr,
   input logic [DW-1:0]     cpu_wdata,
   input logic [DW-1:0]     cpu_bus_last,
   input logic [DW-1:0]     cpu_rdata,
   input logic              rendering,
   input logic [VID_AW-1:0] vid_addr,
   input logic              vid_wr,
   input logic [DW-1:0]     vid_rdata,
   input logic              ciram_hit,
   input logic [RAM_AW:0]   ciram_addr,
   input logic              ciram_we,
   input xmode_t            mode_q,
   input logic              ram_we,
   input logic [DW-1:0]     ram_wdata
);

   logic in_win;
   assign in_win = (cpu_addr[CPU_AW-1:RAM_AW] == WIN_BASE[CPU_AW-1:RAM_AW]);

   // R6: mode register takes the written value
   a_r6_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == MODE_ADDR) |=> (mode_q == $past(cpu_wdata[1:0])));

   // R5: mode 3 never stores
   a_r5_ro_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd3) |-> !ram_we);

   // R4: blank-time write in low modes stores zero
   a_r4_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !mode_q[1] && !rendering) |-> (ram_wdata == '0));

   // R2: outside the window nothing is stored
   a_r2_no_store_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !in_win) |-> !ram_we);

   // R10: console write strobe only with a console route
   a_r10_we_console: assert property (@(posedge clk) disable iff (!rst_n)
      ciram_we |-> (ciram_hit && vid_wr));

   // R7: console routes keep the offset
   a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ciram_hit |-> (ciram_addr[RAM_AW-1:0] == vid_addr[RAM_AW-1:0]));

   if (!OUT_REG) begin : g_comb_chk
      // R3: low modes and non-window reads give the bus value
      a_r3_bus_value: assert property (@(posedge clk) disable iff (!rst_n)
         (!in_win || !mode_q[1]) |-> (cpu_rdata == cpu_bus_last));
      // R7: console routes return zero data
      a_r7_console_zero: assert property (@(posedge clk) disable iff (!rst_n)
         ciram_hit |-> (vid_rdata == '0));
   end

endmodule

bind xram_ntmap xram_ntmap_chk #(
   .CPU_AW(CPU_AW), .RAM_AW(RAM_AW), .DW(DW), .VID_AW(VID_AW),
   .WIN_BASE(WIN_BASE), .MODE_ADDR(MODE_ADDR), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
   .cpu_wdata(cpu_wdata), .cpu_bus_last(cpu_bus_last), .cpu_rdata(cpu_rdata),
   .rendering(rendering), .vid_addr(vid_addr), .vid_wr(vid_wr),
   .vid_rdata(vid_rdata), .ciram_hit(ciram_hit), .ciram_addr(ciram_addr),
   .ciram_we(ciram_we), .mode_q(mode_q), .ram_we(ram_we),
   .ram_wdata(ram_wdata)
);

// File: tb/xram_ntmap_bench.sv
module xram_ntmap_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_bus_last = 8'hA5;
   logic [7:0]  cpu_rdata;
   logic        rendering = 1'b0;
   logic [13:0] vid_addr = '0;
   logic        vid_wr = 1'b0;
   logic [7:0]  vid_wdata = '0;
   logic [8:0]  hcount = '0;
   logic [7:0]  fill_tile = 8'h3C;
   logic [7:0]  fill_color = 8'hC3;
   logic [7:0]  vid_rdata;
   logic        ciram_hit;
   logic [10:0] ciram_addr;
   logic        ciram_we;
   logic [7:0]  ciram_wdata;

   always #5 clk = ~clk;

   xram_ntmap u_xram_ntmap (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_bus_last(cpu_bus_last),
      .cpu_rdata(cpu_rdata), .rendering(rendering), .vid_addr(vid_addr),
      .vid_wr(vid_wr), .vid_wdata(vid_wdata), .hcount(hcount),
      .fill_tile(fill_tile), .fill_color(fill_color), .vid_rdata(vid_rdata),
      .ciram_hit(ciram_hit), .ciram_addr(ciram_addr), .ciram_we(ciram_we),
      .ciram_wdata(ciram_wdata)
   );

   int   n_checks = 0;
   int   n_errors = 0;
   logic [7:0] exp_mem [1024];
   logic [1:0] exp_mode = 2'd0;
   logic [7:0] exp_nt = 8'h00;
   int   cycles = 0;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
      // bench model built from R2, R4, R5, R6
      if (a == 16'h5104) exp_mode = d[1:0];
      else if (a == 16'h5105) exp_nt = d;
      else if (a[15:10] == 6'b010111 && exp_mode != 2'd3)
         exp_mem[a[9:0]] = (exp_mode < 2 && !rendering) ? 8'h00 : d;
   endtask

   task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wr = 1'b0;
      #1 d = cpu_rdata;
   endtask

   task automatic cpu_read_check(input logic [15:0] a, input string req);
      logic [7:0] d;
      logic [7:0] e;
      cpu_read(a, d);
      if (a[15:10] == 6'b010111 && exp_mode >= 2) e = exp_mem[a[9:0]];
      else e = cpu_bus_last;
      check(d === e, req, d, e);
   endtask

   task automatic vid_check(input int q, input int off, input int hc, input string req);
      logic [1:0] s;
      logic [7:0] e;
      @(negedge clk);
      vid_addr = 14'((q << 10) | off);
      hcount = 9'(hc);
      s = exp_nt[2*q +: 2];
      #1;
      case (s)
         2'd0, 2'd1: begin
            check(ciram_hit === 1'b1, req, ciram_hit, 1);
            check(ciram_addr === {s[0], 10'(off)}, req, ciram_addr, {s[0], 10'(off)});
            e = 8'h00;
         end
         2'd2: begin
            check(ciram_hit === 1'b0, req, ciram_hit, 0);
            e = (exp_mode < 2) ? exp_mem[off] : 8'h00;
         end
         default: begin
            check(ciram_hit === 1'b0, req, ciram_hit, 0);
            e = hcount[1] ? fill_color : fill_tile;
         end
      endcase
      check(vid_rdata === e, req, vid_rdata, e);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
         end
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cpu_read(16'h5C10, d);
      check(d === 8'hA5, "R1 window read after reset", d, 8'hA5);
      for (int q = 0; q < 4; q++) vid_check(q, 5 + q, 0, "R1 page0 after reset");

      // R6, R5: mode 2 fill of every location, then sweep back
      cpu_write(16'h5104, 8'h02);
      for (int i = 0; i < 1024; i++)
         cpu_write(16'h5C00 | 16'(i), 8'((i * 7 + 3) ^ (i >> 3)));
      for (int i = 0; i < 1024; i++) cpu_read_check(16'h5C00 | 16'(i), "R5 mode2 store");

      // R2: addresses just outside the window
      cpu_write(16'h5BFF, 8'h11);
      cpu_write(16'h6000, 8'h22);
      cpu_write(16'hDC00, 8'h33);
      cpu_read_check(16'h5BFF, "R2 below window");
      cpu_read_check(16'h6000, "R2 above window");
      cpu_read_check(16'hDC00, "R2 alias high bit");
      cpu_read_check(16'h5FFF, "R2 last location kept");
      cpu_read_check(16'h5C00, "R2 first location kept");

      // R4, R3: mode 0 and mode 1 writes in and out of rendering
      for (int m = 0; m < 2; m++) begin
         cpu_write(16'h5104, 8'(m));
         for (int i = 0; i < 64; i++) begin
            rendering = i[0];
            cpu_write(16'h5C00 | 16'(64 * m + i), 8'(~i));
         end
         rendering = 1'b0;
         for (int i = 0; i < 8; i++) cpu_read_check(16'h5C00 | 16'(64 * m + i), "R3 low mode bus");
      end
      cpu_write(16'h5104, 8'h02);
      for (int i = 0; i < 128; i++) cpu_read_check(16'h5C00 | 16'(i), "R4 render gated store");

      // R5, R3: mode 3 ignores writes, reads RAM
      cpu_write(16'h5104, 8'h03);
      for (int i = 128; i < 192; i++) cpu_write(16'h5C00 | 16'(i), 8'hEE);
      for (int i = 100; i < 256; i++) cpu_read_check(16'h5C00 | 16'(i), "R5 mode3 read only");

      // R6, R7, R8, R9: selector set 0xE4 (q0 p0, q1 p1, q2 ram, q3 fill)
      cpu_write(16'h5105, 8'hE4);
      for (int m = 0; m < 4; m++) begin
         cpu_write(16'h5104, 8'(m));
         for (int q = 0; q < 4; q++)
            for (int off = m; off < 1024; off += 37)
               vid_check(q, off, off + q, "R8 R9 R7 route E4");
      end
      // permutation 0x1B (q0 fill, q1 ram, q2 p1, q3 p0)
      cpu_write(16'h5105, 8'h1B);
      cpu_write(16'h5104, 8'h01);
      for (int q = 0; q < 4; q++)
         for (int hc = 0; hc < 16; hc++)
            vid_check(q, hc * 61 + q, hc, "R6 R9 route 1B");

      // R10: video writes
      cpu_write(16'h5105, 8'hE4);
      for (int q = 0; q < 4; q++) begin
         @(negedge clk);
         vid_addr = 14'((q << 10) | 20);
         vid_wdata = 8'h99;
         vid_wr = 1'b1;
         #1;
         check(ciram_we === (q < 2), "R10 console write strobe", ciram_we, (q < 2));
         check(ciram_wdata === 8'h99, "R10 write data", ciram_wdata, 8'h99);
         @(negedge clk);
         vid_wr = 1'b0;
      end
      cpu_write(16'h5104, 8'h02);
      cpu_read_check(16'h5C14, "R10 ram untouched by video");

      // R1: reset again clears mode and selectors
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      exp_mode = 2'd0;
      exp_nt = 8'h00;
      cpu_read_check(16'h5C14, "R1 mode cleared");
      for (int q = 0; q < 4; q++) vid_check(q, 99, 0, "R1 selectors cleared");

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule